// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of general-purpose pins behind a simple register port. The pin count is a parameter with a default of 192, and it must be a multiple of 32. Each register type is an array of 32-bit words with one bit per pin. Software sets the pin direction and drives output values through separate set and clear strobes. It can read back the conditioned level of every input.

Every input passes through a two-flop synchroniser and then an optional glitch filter. The conditioned value feeds a detector that can be set to edges or to levels. Each event is latched into an interrupt status bit and also into a wake-source bit. A single interrupt line reports any status bit that is unmasked, and a single wake line reports any wake-source bit that is unmasked. Both status arrays are cleared by writing ones.

The register port is single-cycle. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `reg_addr`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero and `pin_oe`, `pin_out`, `irq` and `wake` are all low, so every pin starts as an input with no interrupt enabled.
- R2: The word for pin p of a register type is at that type's base plus 4*(p/32), and p%32 is the bit within the word. The base offsets are: 0x004 input level (read-only), 0x01c direction, 0x034 output-set, 0x04c output-clear, 0x064 rising enable, 0x07c falling enable, 0x094 filter bypass, 0x0ac interrupt mask, 0x0c4 interrupt status, 0x300 detect type, 0x318 level polarity, 0x400 wake mask, 0x418 wake source.
- R3: A direction bit of 1 makes `pin_oe` high for that pin. A direction bit of 0 makes it an input.
- R4: The output-set and output-clear words are write-only and read as zero. A 1 bit sets or clears that pin's output latch, which drives `pin_out`. A 0 bit leaves the latch unchanged.
- R5: With the filter bypassed, a change on `pin_in` appears in the input-level word after two clock edges.
- R6: With the bypass bit at 0, an input must hold a new value for 3 consecutive synchronised samples before it is accepted. A 2-cycle pulse is therefore ignored. A 3-cycle pulse appears in the input-level word after 5 edges.
- R7: In edge mode (detect-type bit 0), the rising and falling enables act independently. A transition that is not enabled sets no status bit.
- R8: In level mode (detect-type bit 1), the status bit is set on every cycle that the active level is present. Polarity 0 means active-high and polarity 1 means active-low. Clearing the bit has no lasting effect while the level persists.
- R9: Writing 1 to an interrupt status bit clears it, and writing 0 leaves it unchanged. `irq` is high whenever some status bit and its mask bit are both 1.
- R10: If a status bit is cleared on the same edge that a new event is detected for it, the event wins and the bit stays set.
- R11: Every detected event also sets that pin's wake-source bit. Writing 1 to a wake-source bit clears it. `wake` is high whenever a wake-source bit and its wake-mask bit are both 1.
- R12: When a status bit is set but its mask bit is 0, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| pin_in | input | NPINS | Raw pin inputs |
| pin_out | output | NPINS | Output latch values |
| pin_oe | output | NPINS | Output enables (direction) |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Combined wake request |

## Verification
A wrong conditioning state shows up in the input-level word at a shifted cycle count. It is either early or late against the two-edge bypass latency or the five-edge filtered latency, or a short pulse is accepted that should have been rejected. A wrong status or wake-source bit is visible on `irq` or `wake` as soon as the matching mask bit is set, and it can also be read back on the next cycle. A wrong priority between a clear and an event only shows up when the two fall on the same edge, so that edge is lined up exactly and the status bit is read back afterwards.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = 32;

  localparam logic [ADDR_W-1:0] OFS_LEVEL = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h01c;
  localparam logic [ADDR_W-1:0] OFS_SET   = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h04c;
  localparam logic [ADDR_W-1:0] OFS_RISE  = 12'h064;
  localparam logic [ADDR_W-1:0] OFS_FALL  = 12'h07c;
  localparam logic [ADDR_W-1:0] OFS_BYP   = 12'h094;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h0ac;
  localparam logic [ADDR_W-1:0] OFS_STS   = 12'h0c4;
  localparam logic [ADDR_W-1:0] OFS_TYPE  = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_POL   = 12'h318;
  localparam logic [ADDR_W-1:0] OFS_WMASK = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_WSRC  = 12'h418;

  // byte address of word w of a register type
  function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] base, int unsigned w);
    return base + ADDR_W'(w * (WORD_W / 8));
  endfunction

  function automatic bit hit(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base, int unsigned w);
    return a == word_addr(base, w);
  endfunction
endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
  parameter int unsigned STABLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic bypass_i,
  output logic cond_o
);
  localparam int unsigned CW = (STABLE > 1) ? $clog2(STABLE) : 1;

  logic          sync1_q, sync2_q;
  logic          filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
    end
  end

  // a differing sample is always the same new value for a single bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (sync2_q == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(STABLE - 1)) begin
      filt_q <= sync2_q;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cond_o = bypass_i ? sync2_q : filt_q;
endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det #(
  parameter int unsigned N = 192
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  input  logic [N-1:0] lvl_sel_i,
  input  logic [N-1:0] lvl_pol_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rose, fell, lvl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cond_i;
  end

  assign rose    = cond_i & ~prev_q;
  assign fell    = ~cond_i & prev_q;
  assign lvl_hit = cond_i ^ lvl_pol_i;

  assign evt_o = (lvl_sel_i & lvl_hit) |
                 (~lvl_sel_i & ((rise_en_i & rose) | (fall_en_i & fell)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 192,
  parameter int unsigned STABLE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq,
  output logic              wake
);
  localparam int unsigned NWORDS = NPINS / WORD_W;

  logic [NPINS-1:0] dir_q, out_q, rise_q, fall_q, byp_q, mask_q;
  logic [NPINS-1:0] sts_q, type_q, pol_q, wmask_q, wsrc_q;

  // named internal events
  logic [NPINS-1:0] cond;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] sts_clr;
  logic [NPINS-1:0] wsrc_clr;
  logic [NPINS-1:0] out_set;
  logic [NPINS-1:0] out_clr;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_in_cond #(.STABLE(STABLE)) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pin_in[p]),
      .bypass_i (byp_q[p]),
      .cond_o   (cond[p])
    );
  end

  gpio_evt_det #(.N(NPINS)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_i    (cond),
    .rise_en_i (rise_q),
    .fall_en_i (fall_q),
    .lvl_sel_i (type_q),
    .lvl_pol_i (pol_q),
    .evt_o     (evt)
  );

  // write-one strobes
  always_comb begin
    sts_clr  = '0;
    wsrc_clr = '0;
    out_set  = '0;
    out_clr  = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (wr_en && hit(reg_addr, OFS_STS, w))   sts_clr[w*WORD_W +: WORD_W]  = reg_wdata;
      if (wr_en && hit(reg_addr, OFS_WSRC, w))  wsrc_clr[w*WORD_W +: WORD_W] = reg_wdata;
      if (wr_en && hit(reg_addr, OFS_SET, w))   out_set[w*WORD_W +: WORD_W]  = reg_wdata;
      if (wr_en && hit(reg_addr, OFS_CLR, w))   out_clr[w*WORD_W +: WORD_W]  = reg_wdata;
    end
  end

  // plain read/write configuration words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      byp_q   <= '0;
      mask_q  <= '0;
      type_q  <= '0;
      pol_q   <= '0;
      wmask_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (hit(reg_addr, OFS_DIR, w))   dir_q[w*WORD_W +: WORD_W]   <= reg_wdata;
        if (hit(reg_addr, OFS_RISE, w))  rise_q[w*WORD_W +: WORD_W]  <= reg_wdata;
        if (hit(reg_addr, OFS_FALL, w))  fall_q[w*WORD_W +: WORD_W]  <= reg_wdata;
        if (hit(reg_addr, OFS_BYP, w))   byp_q[w*WORD_W +: WORD_W]   <= reg_wdata;
        if (hit(reg_addr, OFS_MASK, w))  mask_q[w*WORD_W +: WORD_W]  <= reg_wdata;
        if (hit(reg_addr, OFS_TYPE, w))  type_q[w*WORD_W +: WORD_W]  <= reg_wdata;
        if (hit(reg_addr, OFS_POL, w))   pol_q[w*WORD_W +: WORD_W]   <= reg_wdata;
        if (hit(reg_addr, OFS_WMASK, w)) wmask_q[w*WORD_W +: WORD_W] <= reg_wdata;
      end
    end
  end

  // output latch, status and wake source: new event beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      sts_q  <= '0;
      wsrc_q <= '0;
    end else begin
      out_q  <= (out_q | out_set) & ~out_clr;
      sts_q  <= (sts_q & ~sts_clr) | evt;
      wsrc_q <= (wsrc_q & ~wsrc_clr) | evt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (hit(reg_addr, OFS_LEVEL, w)) reg_rdata = cond[w*WORD_W +: WORD_W];
      if (hit(reg_addr, OFS_DIR, w))   reg_rdata = dir_q[w*WORD_W +: WORD_W];
      if (hit(reg_addr, OFS_RISE, w))  reg_rdata = rise_q[w*WORD_W +: WORD_W];
      if (hit(reg_addr, OFS_FALL, w))  reg_rdata = fall_q[w*WORD_W +: WORD_W];
      if (hit(reg_addr, OFS_BYP, w))   reg_rdata = byp_q[w*WORD_W +: WORD_W];
      if (hit(reg_addr, OFS_MASK, w))  reg_rdata = mask_q[w*WORD_W +: WORD_W];
      if (hit(reg_addr, OFS_STS, w))   reg_rdata = sts_q[w*WORD_W +: WORD_W];
      if (hit(reg_addr, OFS_TYPE, w))  reg_rdata = type_q[w*WORD_W +: WORD_W];
      if (hit(reg_addr, OFS_POL, w))   reg_rdata = pol_q[w*WORD_W +: WORD_W];
      if (hit(reg_addr, OFS_WMASK, w)) reg_rdata = wmask_q[w*WORD_W +: WORD_W];
      if (hit(reg_addr, OFS_WSRC, w))  reg_rdata = wsrc_q[w*WORD_W +: WORD_W];
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(sts_q & mask_q);
  assign wake    = |(wsrc_q & wmask_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned NPINS = 192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] pin_out,
  input logic             irq,
  input logic             wake,
  input logic [NPINS-1:0] sts_q,
  input logic [NPINS-1:0] sts_clr,
  input logic [NPINS-1:0] evt,
  input logic [NPINS-1:0] wmask_q
);
  // R9
  sts_clear_only_by_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sts_q & $past(sts_q) & ~$past(sts_clr)) == '0));

  // R10
  evt_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((sts_q & $past(evt)) == $past(evt)));

  // R3
  dir_change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != $past(pin_oe)) |-> $past(wr_en));

  // R4
  out_change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out != $past(pin_out)) |-> $past(wr_en));

  // R11
  wake_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (wmask_q != '0));

  // R12
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .pin_oe  (pin_oe),
  .pin_out (pin_out),
  .irq     (irq),
  .wake    (wake),
  .sts_q   (sts_q),
  .sts_clr (sts_clr),
  .evt     (evt),
  .wmask_q (wmask_q)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 192;

  localparam logic [11:0] A_LVL = 12'h004, A_DIR = 12'h01c, A_SET = 12'h034, A_CLR = 12'h04c;
  localparam logic [11:0] A_RISE = 12'h064, A_FALL = 12'h07c, A_BYP = 12'h094, A_MASK = 12'h0ac;
  localparam logic [11:0] A_STS = 12'h0c4, A_TYPE = 12'h300, A_POL = 12'h318;
  localparam logic [11:0] A_WMASK = 12'h400, A_WSRC = 12'h418;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq, wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.NPINS(NP)) i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .wake(wake)
  );

  // own address arithmetic: word stride is four bytes, 32 pins per word
  function automatic logic [11:0] addr_of(logic [11:0] base, int pin);
    return base + 12'((pin >> 5) << 2);
  endfunction
  function automatic logic [31:0] bit_of(int pin);
    return 32'h1 << (pin & 31);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pin_oe", 32'(pin_oe != '0), 0);
    chk("R1 pin_out", 32'(pin_out != '0), 0);
    chk("R1 irq/wake", {30'b0, irq, wake}, 0);
    rd(addr_of(A_DIR, 191), d); chk("R1 dir word5", d, 0);
    rd(addr_of(A_STS, 0), d);   chk("R1 status word0", d, 0);
  endtask

  task automatic t_dir_out();
    logic [31:0] d;
    wr(addr_of(A_DIR, 37), bit_of(37));
    chk("R3 oe pin37", 32'(pin_oe[37]), 1);
    chk("R2 oe only pin37", 32'($countones(pin_oe)), 1);
    wr(addr_of(A_SET, 37), bit_of(37));
    chk("R4 set pin37", 32'(pin_out[37]), 1);
    wr(addr_of(A_SET, 37), 32'h0);
    chk("R4 zero set no effect", 32'(pin_out[37]), 1);
    wr(addr_of(A_CLR, 37), 32'h0);
    chk("R4 zero clear no effect", 32'(pin_out[37]), 1);
    rd(addr_of(A_SET, 37), d); chk("R4 set reads zero", d, 0);
    wr(addr_of(A_CLR, 37), bit_of(37));
    chk("R4 clear pin37", 32'(pin_out[37]), 0);
    wr(addr_of(A_SET, 191), bit_of(191));
    chk("R2 set pin191 top bit", {31'b0, pin_out[191]}, 1);
    wr(addr_of(A_CLR, 191), bit_of(191));
    wr(addr_of(A_DIR, 37), 32'h0);
    chk("R3 back to input", 32'(pin_oe[37]), 0);
  endtask

  task automatic t_level_read();
    logic [31:0] d;
    wr(addr_of(A_BYP, 130), bit_of(130));
    pin_in[130] = 1'b1;
    cycles(1);
    rd(addr_of(A_LVL, 130), d); chk("R5 level after 1 edge", d & bit_of(130), 0);
    cycles(1);
    rd(addr_of(A_LVL, 130), d); chk("R5 level after 2 edges", d & bit_of(130), bit_of(130));
    pin_in[130] = 1'b0;
    cycles(3);
    wr(addr_of(A_BYP, 130), 0);
  endtask

  task automatic t_filter();
    logic [31:0] d;
    wr(addr_of(A_RISE, 3), bit_of(3));
    wr(addr_of(A_MASK, 3), bit_of(3));
    pin_in[3] = 1'b1; cycles(2); pin_in[3] = 1'b0;
    cycles(8);
    rd(addr_of(A_LVL, 3), d); chk("R6 2-cycle pulse level", d & bit_of(3), 0);
    chk("R6 2-cycle pulse irq", 32'(irq), 0);
    pin_in[3] = 1'b1; cycles(3); pin_in[3] = 1'b0;
    rd(addr_of(A_LVL, 3), d); chk("R6 before accept", d & bit_of(3), 0);
    cycles(2);
    rd(addr_of(A_LVL, 3), d); chk("R6 3-cycle pulse accepted", d & bit_of(3), bit_of(3));
    cycles(1);
    chk("R6 filtered edge irq", 32'(irq), 1);
    cycles(8);
    wr(addr_of(A_STS, 3), bit_of(3));
    chk("R9 cleared irq", 32'(irq), 0);
    wr(addr_of(A_RISE, 3), 0);
    wr(addr_of(A_MASK, 3), 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(addr_of(A_BYP, 5), bit_of(5));
    wr(addr_of(A_RISE, 5), bit_of(5));
    wr(addr_of(A_MASK, 5), bit_of(5));
    pin_in[5] = 1'b1; cycles(2);
    chk("R7 no irq yet", 32'(irq), 0);
    cycles(1);
    chk("R7 rising irq", 32'(irq), 1);
    wr(addr_of(A_STS, 5), 32'h0);
    chk("R9 zero write keeps status", 32'(irq), 1);
    wr(addr_of(A_STS, 5), bit_of(5));
    chk("R9 w1c clears", 32'(irq), 0);
    pin_in[5] = 1'b0; cycles(5);
    chk("R7 falling not enabled", 32'(irq), 0);
    wr(addr_of(A_RISE, 5), 0);
    wr(addr_of(A_FALL, 5), bit_of(5));
    pin_in[5] = 1'b1; cycles(5);
    chk("R7 rising disabled", 32'(irq), 0);
    pin_in[5] = 1'b0; cycles(3);
    rd(addr_of(A_STS, 5), d); chk("R7 falling status", d, bit_of(5));
    wr(addr_of(A_STS, 5), bit_of(5));
    wr(addr_of(A_FALL, 5), 0);
    wr(addr_of(A_MASK, 5), 0);
    wr(addr_of(A_BYP, 5), 0);
  endtask

  task automatic t_level_irq();
    logic [31:0] d;
    wr(addr_of(A_BYP, 40), bit_of(40));
    wr(addr_of(A_TYPE, 40), bit_of(40));
    wr(addr_of(A_MASK, 40), bit_of(40));
    chk("R8 low idle no irq", 32'(irq), 0);
    pin_in[40] = 1'b1; cycles(3);
    chk("R8 active-high irq", 32'(irq), 1);
    wr(addr_of(A_STS, 40), bit_of(40));
    rd(addr_of(A_STS, 40), d); chk("R8 clear while active", d, bit_of(40));
    pin_in[40] = 1'b0; cycles(3);
    wr(addr_of(A_STS, 40), bit_of(40));
    chk("R8 cleared after release", 32'(irq), 0);
    wr(addr_of(A_POL, 40), bit_of(40));
    cycles(1);
    chk("R8 active-low irq", 32'(irq), 1);
    pin_in[40] = 1'b1; cycles(3);
    wr(addr_of(A_STS, 40), bit_of(40));
    chk("R8 active-low released", 32'(irq), 0);
    wr(addr_of(A_TYPE, 40), 0);
    wr(addr_of(A_POL, 40), 0);
    wr(addr_of(A_MASK, 40), 0);
    pin_in[40] = 1'b0; cycles(3);
    wr(addr_of(A_STS, 40), 32'hffff_ffff);
    wr(addr_of(A_BYP, 40), 0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    wr(addr_of(A_BYP, 70), bit_of(70));
    wr(addr_of(A_RISE, 70), bit_of(70));
    wr(addr_of(A_FALL, 70), bit_of(70));
    pin_in[70] = 1'b1; cycles(3);
    rd(addr_of(A_STS, 70), d); chk("R7 both enables rise", d, bit_of(70));
    pin_in[70] = 1'b0; cycles(2);
    wr(addr_of(A_STS, 70), bit_of(70));   // lands on the falling-event edge
    rd(addr_of(A_STS, 70), d); chk("R10 event beats clear", d, bit_of(70));
    wr(addr_of(A_STS, 70), bit_of(70));
    rd(addr_of(A_STS, 70), d); chk("R10 later clear works", d, 0);
    wr(addr_of(A_RISE, 70), 0);
    wr(addr_of(A_FALL, 70), 0);
    wr(addr_of(A_BYP, 70), 0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    wr(addr_of(A_BYP, 100), bit_of(100));
    wr(addr_of(A_RISE, 100), bit_of(100));
    pin_in[100] = 1'b1; cycles(3);
    chk("R12 masked status no irq", 32'(irq), 0);
    rd(addr_of(A_STS, 100), d); chk("R12 status set", d, bit_of(100));
    chk("R11 no wake without mask", 32'(wake), 0);
    rd(addr_of(A_WSRC, 100), d); chk("R11 wake source captured", d, bit_of(100));
    wr(addr_of(A_WMASK, 100), bit_of(100));
    chk("R11 wake asserted", 32'(wake), 1);
    wr(addr_of(A_WSRC, 100), bit_of(100));
    chk("R11 wake source w1c", 32'(wake), 0);
    wr(addr_of(A_WMASK, 100), 0);
    wr(addr_of(A_STS, 100), bit_of(100));
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_dir_out();
    t_level_read();
    t_filter();
    t_edge();
    t_level_irq();
    t_collision();
    t_wake();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule